// File: doc/BRIEF.md
# Data-Strobe Serial Codec

This block turns parallel link words into a two-wire data-strobe bit stream for the cable drivers. It also turns a received data-strobe pair back into parallel words. The whole block runs on a bit-rate clock that is eight times the word rate. A free-running phase counter splits each word period into eight slots.

One datapath serves three line rates. In each word period the link offers 2, 4 or 8 bits, and the speed code picks how many:
- 2 bits: one bit leaves every fourth clock.
- 4 bits: one bit leaves every second clock.
- 8 bits: one bit leaves every clock.

Bits leave most significant first. The data line carries the bit itself. The strobe line flips only when a bit repeats the previous data value, so exactly one of the two lines moves per transmitted bit.

On the receive side, every change in the exclusive-OR of data and strobe marks a new bit, and the data line is sampled at that point. Once a word's worth of bits has arrived, the word is presented left-aligned for one clock.

Top module: `ds_link_codec`

## Requirements
- R1: During reset and until the first word is sent, the transmit data and strobe lines are low and `rx_valid` is low.
- R2: `word_slot` is high for exactly one clock in every eight clocks; the clock edge at which it is high is the word load edge.
- R3: Speed code 0 takes 2 bits per word from `tx_data[7:6]`. Code 1 takes 4 bits from `tx_data[7:4]`. Code 2 takes all 8 bits. Code 3 behaves exactly as code 2.
- R4: A word offered with `tx_valid` high at the load edge is sent most significant bit first. Its first bit appears on `txb_data` right after the load edge. Each following bit follows 4, 2 or 1 clocks later for codes 0, 1 and 2.
- R5: For each bit sent, `txb_data` takes the bit value. `txa_strobe` inverts only when the new bit equals the previous data value. No clock ever sees both lines change.
- R6: When `tx_valid` is low at a load edge, both transmit lines hold their values for the whole following word period.
- R7: Data lines outside the bits selected by the speed code have no effect on the transmitted stream or on the received word.
- R8: Each change of `rxa_data` XOR `rxb_strobe` captures one bit. After 2, 4 or 8 bits (by `speed`), `rx_valid` pulses for one clock. At that clock `rx_word` holds the bits left-aligned, first bit in bit 7, with the remaining low bits zero.
- R9: Words offered at consecutive load edges are sent as one unbroken bit stream, and the strobe rule of R5 carries across the word boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, eight clocks per word period |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| speed | input | 2 | Rate code: 0 two bits, 1 four bits, 2 or 3 eight bits per word |
| tx_valid | input | 1 | A word is offered at this load edge |
| tx_data | input | 8 | Parallel transmit word, used from bit 7 downward |
| word_slot | output | 1 | High in the clock whose closing edge loads a word |
| txb_data | output | 1 | Encoded serial data line |
| txa_strobe | output | 1 | Encoded strobe line |
| rxa_data | input | 1 | Received data line |
| rxb_strobe | input | 1 | Received strobe line |
| rx_valid | output | 1 | One-clock pulse when a received word is complete |
| rx_word | output | 8 | Received word, left-aligned |

## Verification
The assertions take two things for granted. First, `speed` changes only while no word is being sent and the decoder has finished its last whole word. Second, the receive pair changes at most once per clock, as a legal encoder produces it. The stimulus meets both. It loops the transmit pair straight back into the receive inputs. It changes the rate code only after a drain of more than two word periods with `tx_valid` low. It raises `tx_valid` only at clocks where `word_slot` is high.

// File: rtl/ds_pkg.sv
package ds_pkg;

  typedef enum logic [1:0] {
    SPD_NARROW = 2'd0,
    SPD_HALF   = 2'd1,
    SPD_FULL   = 2'd2,
    SPD_FULL_B = 2'd3
  } ds_speed_e;

  // Bits carried per word period for a rate code, given the full word width.
  function automatic int unsigned lanes_for(input logic [1:0] code,
                                            input int unsigned word_w);
    case (code)
      2'd0:    return word_w / 4;
      2'd1:    return word_w / 2;
      default: return word_w;
    endcase
  endfunction

endpackage

// File: rtl/ds_phase_gen.sv
module ds_phase_gen #(
  parameter int unsigned WORD_W = 8,
  localparam int unsigned PH_W  = $clog2(WORD_W),
  localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] lanes,
  output logic             slot,
  output logic             bit_en
);

  logic [PH_W-1:0] ph_q, ph_d;
  logic [PH_W-1:0] step_mask;

  always_comb begin
    ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  // Slot spacing between bits is WORD_W / lanes clocks, a power of two.
  always_comb begin
    step_mask = PH_W'((WORD_W / ((lanes == '0) ? 1 : int'(lanes))) - 1);
    slot      = (ph_q == '0);
    bit_en    = ((ph_q & step_mask) == '0);
  end

endmodule

// File: rtl/ds_tx_encoder.sv
module ds_tx_encoder #(
  parameter int unsigned WORD_W = 8,
  localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot,
  input  logic              bit_en,
  input  logic [CNT_W-1:0]  lanes,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_data,
  output logic              line_data,
  output logic              line_strobe
);

  logic [WORD_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              data_q, data_d;
  logic              strb_q, strb_d;
  logic              emit;
  logic              nbit;

  always_comb begin
    emit   = 1'b0;
    nbit   = data_q;
    sr_d   = sr_q;
    left_d = left_q;
    if (slot) begin
      left_d = '0;
      if (tx_valid) begin
        emit   = 1'b1;
        nbit   = tx_data[WORD_W-1];
        sr_d   = tx_data << 1;
        left_d = lanes - 1'b1;
      end
    end else if (bit_en && (left_q != '0)) begin
      emit   = 1'b1;
      nbit   = sr_q[WORD_W-1];
      sr_d   = sr_q << 1;
      left_d = left_q - 1'b1;
    end
  end

  // Strobe flips on a repeated bit, so exactly one line moves per bit.
  always_comb begin
    data_d = emit ? nbit : data_q;
    strb_d = (emit && (nbit == data_q)) ? ~strb_q : strb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      left_q <= '0;
      data_q <= 1'b0;
      strb_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      left_q <= left_d;
      data_q <= data_d;
      strb_q <= strb_d;
    end
  end

  assign line_data   = data_q;
  assign line_strobe = strb_q;

endmodule

// File: rtl/ds_rx_decoder.sv
module ds_rx_decoder #(
  parameter int unsigned WORD_W = 8,
  localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  lanes,
  input  logic              line_data,
  input  logic              line_strobe,
  output logic              word_valid,
  output logic [WORD_W-1:0] word
);

  logic              par_q, par_d;
  logic [WORD_W-1:0] acc_q, acc_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              vld_q, vld_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              tick;

  always_comb begin
    par_d  = line_data ^ line_strobe;
    tick   = (par_d != par_q);
    acc_d  = acc_q;
    cnt_d  = cnt_q;
    vld_d  = 1'b0;
    word_d = word_q;
    if (tick) begin
      acc_d = {acc_q[WORD_W-2:0], line_data};
      if ((cnt_q + 1'b1) == lanes) begin
        cnt_d  = '0;
        vld_d  = 1'b1;
        word_d = acc_d << (CNT_W'(WORD_W) - lanes);
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q  <= 1'b0;
      acc_q  <= '0;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
      word_q <= '0;
    end else begin
      par_q  <= par_d;
      acc_q  <= acc_d;
      cnt_q  <= cnt_d;
      vld_q  <= vld_d;
      word_q <= word_d;
    end
  end

  assign word_valid = vld_q;
  assign word       = word_q;

endmodule

// File: rtl/ds_link_codec.sv
module ds_link_codec #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        speed,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_data,
  output logic              word_slot,
  output logic              txb_data,
  output logic              txa_strobe,
  input  logic              rxa_data,
  input  logic              rxb_strobe,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_word
);

  localparam int unsigned CNT_W = $clog2(WORD_W + 1);

  logic             rst_meta_n, rst_sync_n;
  logic [1:0]       spd_q, spd_d;
  logic [CNT_W-1:0] tx_lanes, rx_lanes;
  logic             slot, bit_en;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  // Rate code is captured at each load edge for the transmit path.
  always_comb begin
    spd_d = slot ? speed : spd_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) spd_q <= 2'd0;
    else             spd_q <= spd_d;
  end

  always_comb begin
    tx_lanes = CNT_W'(ds_pkg::lanes_for(spd_q, WORD_W));
    rx_lanes = CNT_W'(ds_pkg::lanes_for(speed, WORD_W));
  end

  ds_phase_gen #(.WORD_W(WORD_W)) u_phase (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .lanes  (tx_lanes),
    .slot   (slot),
    .bit_en (bit_en)
  );

  ds_tx_encoder #(.WORD_W(WORD_W)) u_enc (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .slot        (slot),
    .bit_en      (bit_en),
    .lanes       (tx_lanes),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .line_data   (txb_data),
    .line_strobe (txa_strobe)
  );

  ds_rx_decoder #(.WORD_W(WORD_W)) u_dec (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .lanes       (rx_lanes),
    .line_data   (rxa_data),
    .line_strobe (rxb_strobe),
    .word_valid  (rx_valid),
    .word        (rx_word)
  );

  assign word_slot = slot;

endmodule

// File: rtl/ds_link_codec_chk.sv
module ds_link_codec_chk #(
  parameter int unsigned WORD_W = 8
) (
  input logic              clk,
  input logic              rst_ok,
  input logic [1:0]        speed,
  input logic              tx_valid,
  input logic              word_slot,
  input logic              txb_data,
  input logic              txa_strobe,
  input logic              rx_valid,
  input logic [WORD_W-1:0] rx_word
);

  localparam int unsigned NARROW_PAD = WORD_W - WORD_W / 4;

  a_r2_slot_single: assert property (@(posedge clk) disable iff (!rst_ok)
    word_slot |=> !word_slot);

  a_r5_one_line_moves: assert property (@(posedge clk) disable iff (!rst_ok)
    $countones({txb_data ^ $past(txb_data), txa_strobe ^ $past(txa_strobe)}) <= 1);

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    (word_slot && !tx_valid) |=> ($stable(txb_data) && $stable(txa_strobe)));

  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_ok)
    rx_valid |=> !rx_valid);

  a_r8_narrow_pad: assert property (@(posedge clk) disable iff (!rst_ok)
    (rx_valid && speed == 2'd0) |-> (rx_word[NARROW_PAD-1:0] == '0));

endmodule

bind ds_link_codec ds_link_codec_chk #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_ok     (rst_sync_n),
  .speed      (speed),
  .tx_valid   (tx_valid),
  .word_slot  (word_slot),
  .txb_data   (txb_data),
  .txa_strobe (txa_strobe),
  .rx_valid   (rx_valid),
  .rx_word    (rx_word)
);

// File: tb/ds_link_codec_test.sv
module ds_link_codec_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] speed;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       word_slot, txb_data, txa_strobe, rx_valid;
  logic [7:0] rx_word;

  always #10 clk = ~clk;

  ds_link_codec uut (
    .clk(clk), .rst_n(rst_n), .speed(speed), .tx_valid(tx_valid),
    .tx_data(tx_data), .word_slot(word_slot), .txb_data(txb_data),
    .txa_strobe(txa_strobe), .rxa_data(txb_data), .rxb_strobe(txa_strobe),
    .rx_valid(rx_valid), .rx_word(rx_word)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit cmp_on = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference: a bit queue, a word queue and a phase count.
  bit         slot_s;
  logic       m_data, m_strb;
  bit         bitq[$];
  logic [7:0] wq[$];
  int         k;
  int         m_lanes;

  function automatic int lanes_of(input logic [1:0] s);
    return (s == 2'd0) ? 2 : (s == 2'd1) ? 4 : 8;
  endfunction

  always @(negedge clk) slot_s <= word_slot;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_data = 1'b0; m_strb = 1'b0; k = 0; m_lanes = 2;
      bitq.delete();
    end else begin
      if (slot_s) begin
        if (k > 0) check(k == 7, "R2 slot period", k + 1, 8);
        k = 0;
        m_lanes = lanes_of(speed);
        bitq.delete();
        if (tx_valid) begin
          for (int i = 0; i < m_lanes; i++) bitq.push_back(tx_data[7-i]);
          wq.push_back(tx_data & ~((8'd1 << (8 - m_lanes)) - 8'd1));
        end
      end else begin
        k++;
      end
      if (((k % (8 / m_lanes)) == 0) && bitq.size() > 0) begin
        bit b;
        b = bitq.pop_front();
        if (b == m_data) m_strb = ~m_strb;
        m_data = b;
      end
    end
  end

  // Cycle-by-cycle compare (R4 data line, R5 strobe line) and word compare (R8).
  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      check(txb_data == m_data, "R4 data line", txb_data, m_data);
      check(txa_strobe == m_strb, "R5 strobe line", txa_strobe, m_strb);
      if (rx_valid) begin
        if (wq.size() == 0) check(1'b0, "R8 unexpected word", rx_word, 0);
        else begin
          logic [7:0] e;
          e = wq.pop_front();
          check(rx_word == e, "R8 received word", rx_word, e);
        end
      end
    end
  end

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    while (!word_slot) @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = d;
    @(negedge clk);
    tx_valid = 1'b0;
    tx_data  = 8'h00;
  endtask

  task automatic set_speed(input logic [1:0] s);
    repeat (24) @(negedge clk);
    speed = s;
    repeat (2) @(negedge clk);
  endtask

  task automatic idle_period;
    logic d0, s0;
    @(negedge clk);
    while (!word_slot) @(negedge clk);
    @(negedge clk);
    d0 = txb_data; s0 = txa_strobe;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      check(txb_data == d0 && txa_strobe == s0, "R6 idle hold",
            {txb_data, txa_strobe}, {d0, s0});
    end
  endtask

  initial begin
    rst_n = 1'b0; speed = 2'd0; tx_valid = 1'b0; tx_data = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state of the lines
    check(txb_data == 1'b0 && txa_strobe == 1'b0, "R1 lines in reset",
          {txb_data, txa_strobe}, 0);
    check(rx_valid == 1'b0, "R1 rx_valid in reset", rx_valid, 0);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    check(txb_data == 1'b0 && txa_strobe == 1'b0, "R1 lines after reset",
          {txb_data, txa_strobe}, 0);
    cmp_on = 1'b1;

    // R3 R4 narrow rate, R7 junk below the selected lines
    send(8'hC0); send(8'h40); send(8'h80); send(8'h00); send(8'h7F); send(8'hBF);
    idle_period();                              // R6
    set_speed(2'd1);                            // R3 half rate
    send(8'hA5); send(8'hFF); send(8'h00); send(8'h3C); send(8'h6B);
    idle_period();
    set_speed(2'd2);                            // R9 back to back at full rate
    send(8'h55); send(8'hFF); send(8'h00); send(8'hB7); send(8'h12);
    idle_period();
    set_speed(2'd3);                            // R3 code 3 same as code 2
    send(8'hE1); send(8'h9C); send(8'h00);
    repeat (24) @(negedge clk);
    check(wq.size() == 0, "R8 all words received", wq.size(), 0);
    check(rx_valid == 1'b0, "R8 no stray pulse", rx_valid, 0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule